// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Device

This block is one output cell of a small programmable logic device. An external AND array hands it up to eight product-term results. The cell sums them in an OR gate and applies a programmable polarity inversion. It then either registers the result on a shared clock or passes it straight to the pin. It also chooses where the pin's tri-state enable comes from, and what value is fed back into the array.

Four static configuration inputs select the behaviour:

- Two global architecture bits are shared by every cell of the device.
- A per-cell polarity bit sets the output sense.
- A per-cell I/O bit chooses between registered output and combinatorial I/O.

A build-time parameter marks the cell as one of the two outermost cells of the device. In that position the cell has no feedback path in complex mode.

The pin is modelled as three signals: data out, an output-enable, and the value seen on the pad. The value seen on the pad is whatever drives it, whether that is the cell itself or an outside source.

Top module: `plc_out_cell`

## Requirements
- R1: With `cfg_comb_sel`=0, `cfg_arch_en`=1 and `cfg_io_sel`=0 (registered output), a rising clock edge with `rst_n` high loads the flip-flop. After that edge, `pad_out` equals the OR of all `NUM_PT` product terms sampled at the edge, adjusted for polarity. `pad_out` holds that value until the next edge, even when `pterm` changes.
- R2: In the registered-output configuration, `pad_oe` is the inverse of the shared active-low `oe_n` input. `pterm[0]` is part of the sum and does not act as an enable.
- R3: In the registered-output configuration, `fb_out` equals the flip-flop state, which is always the complement of `pad_out`.
- R4: With `cfg_comb_sel`=0, `cfg_arch_en`=1 and `cfg_io_sel`=1 (combinatorial I/O), `pad_out` is the polarity-adjusted OR of `pterm[NUM_PT-1:1]`, with no clock delay. `pad_oe` equals `pterm[0]`, and `oe_n` has no effect.
- R5: Polarity follows `cfg_pol_hi`. When it is 1, `pad_out` carries the sum unchanged (active high). When it is 0, `pad_out` carries the complement of the sum (active low). This holds in every configuration that drives data.
- R6: With `cfg_comb_sel`=1 and `cfg_arch_en`=1 (complex mode), the value of `cfg_io_sel` has no effect. `pad_out` is the polarity-adjusted OR of `pterm[NUM_PT-1:1]`, `pad_oe` equals `pterm[0]`, and `oe_n` has no effect.
- R7: In the combinatorial I/O configuration, and in complex mode when `EDGE_CELL`=0, `fb_out` equals `pad_in`. This lets a disabled pin serve as an input.
- R8: In complex mode when `EDGE_CELL`=1, `fb_out` is 0 whatever the value of `pad_in`.
- R9: With `cfg_arch_en`=0 the cell is disabled: `pad_oe`, `pad_out` and `fb_out` are all 0.
- R10: A rising clock edge with `rst_n` low clears the flip-flop. In the registered-output configuration, `pad_out` then reads 1 and `fb_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared register clock |
| rst_n | input | 1 | Synchronous active-low reset of the flip-flop |
| pterm | input | NUM_PT | Product-term results from the AND array; bit 0 is the enable term |
| oe_n | input | 1 | Shared active-low output-enable pin, used by registered outputs |
| cfg_comb_sel | input | 1 | Global architecture bit: 0 selects registered mode, 1 selects complex mode |
| cfg_arch_en | input | 1 | Global architecture bit: must be 1 for any driving configuration |
| cfg_pol_hi | input | 1 | Per-cell polarity: 1 is active high, 0 is active low |
| cfg_io_sel | input | 1 | Per-cell I/O select in registered mode: 0 registered, 1 combinatorial I/O |
| pad_in | input | 1 | Value present on the pad |
| pad_out | output | 1 | Data driven towards the pad |
| pad_oe | output | 1 | Tri-state enable of the pad driver |
| fb_out | output | 1 | Feedback signal into the AND array |

## Verification
The bench walks through all 16 settings of the four configuration bits. For each setting it applies every one of the 256 product-term patterns, and it combines each pattern with both levels of `oe_n` and `pad_in`. It runs two instances side by side, one inner cell and one outer cell.

This sweep tells several choices apart:
- Patterns that differ only in `pterm[0]` separate the eight-term sum from the seven-term sum.
- Toggling `oe_n` against `pterm[0]` shows which enable source is in use.
- Toggling `pad_in` shows whether feedback comes from the pad or from the flip-flop.
- Comparing the two instances exposes the missing outer-cell feedback.

Inputs are changed halfway through each cycle, so that a combinatorial leak into the registered output is caught. A separate sequence loads a 0 into the pin and then resets it, which proves the cleared state.

// File: rtl/plc_cell_pkg.sv
// Package: plc_cell_pkg
// Shared configuration type for the output macrocell. The decoded cell
// configuration is carried between sub-blocks as one enum, so that each
// sub-block switches on a named case rather than on raw architecture bits.
package plc_cell_pkg;

    typedef enum logic [2:0] {
        CELL_REG_OUT  = 3'd0,  // registered output, shared enable pin
        CELL_COMB_IO  = 3'd1,  // registered mode, combinatorial I/O
        CELL_CPLX_IO  = 3'd2,  // complex mode, product-term enable
        CELL_DISABLED = 3'd3   // unsupported architecture code
    } cell_cfg_e;

endpackage

// File: rtl/plc_cfg_decode.sv
// Module: plc_cfg_decode
// Turns the two global architecture bits and the per-cell I/O bit into one
// configuration code. It assumes the bits are static while the device runs.
// Any code other than registered or complex mode decodes to disabled.
module plc_cfg_decode
    import plc_cell_pkg::*;
(
    input  logic      comb_sel,
    input  logic      arch_en,
    input  logic      io_sel,
    output cell_cfg_e cfg
);

    // Choose the configuration from the architecture bits.
    always_comb begin
        if (!arch_en) begin
            cfg = CELL_DISABLED;
        end else if (comb_sel) begin
            cfg = CELL_CPLX_IO;
        end else if (io_sel) begin
            cfg = CELL_COMB_IO;
        end else begin
            cfg = CELL_REG_OUT;
        end
    end

endmodule

// File: rtl/plc_sum_term.sv
// Module: plc_sum_term
// OR gate and polarity inverter. A registered output sums every product
// term. All other configurations hold back term 0 for the enable and sum
// the rest. The result has the pin's sense: 1 means drive high.
// Assumes NUM_PT >= 2.
module plc_sum_term
    import plc_cell_pkg::*;
#(
    parameter int NUM_PT = 8
) (
    input  logic [NUM_PT-1:0] pterm,
    input  cell_cfg_e         cfg,
    input  logic              pol_hi,
    output logic              pol_sum
);

    localparam int DATA_PT = NUM_PT - 1;

    logic [NUM_PT-1:0] or_chain;
    logic              sum_all;
    logic              sum_data;

    // Build the OR as a ripple chain from the top term down.
    assign or_chain[NUM_PT-1] = pterm[NUM_PT-1];
    for (genvar i = NUM_PT - 2; i >= 0; i--) begin : g_or
        assign or_chain[i] = or_chain[i+1] | pterm[i];
    end

    // Pick off the full sum and the sum without the enable term.
    assign sum_all  = or_chain[0];
    assign sum_data = (DATA_PT > 0) ? or_chain[1] : 1'b0;

    // Pick the term count and apply the output polarity.
    always_comb begin
        logic raw;
        raw     = (cfg == CELL_REG_OUT) ? sum_all : sum_data;
        pol_sum = pol_hi ? raw : ~raw;
    end

endmodule

// File: rtl/plc_out_reg.sv
// Module: plc_out_reg
// The cell's D flip-flop. It stores the complement of the pin value, so
// that the pin is driven from the inverted flip-flop output and the
// feedback is taken from the true output. The reset is synchronous and
// clears the state.
module plc_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_next,
    output logic q
);

    // Capture the inverted pin value, or clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= ~pin_next;
        end
    end

endmodule

// File: rtl/plc_pad_drive.sv
// Module: plc_pad_drive
// Chooses the pin data, the tri-state enable and the array feedback for
// the decoded configuration. EDGE_CELL selects the outermost-cell variant,
// which has no feedback path in complex mode.
module plc_pad_drive
    import plc_cell_pkg::*;
#(
    parameter bit EDGE_CELL = 1'b0
) (
    input  cell_cfg_e cfg,
    input  logic      pol_sum,
    input  logic      q,
    input  logic      en_term,
    input  logic      oe_n,
    input  logic      pad_in,
    output logic      pad_out,
    output logic      pad_oe,
    output logic      fb_out
);

    logic cplx_fb;

    // Select the complex-mode feedback source for this cell position.
    if (EDGE_CELL) begin : g_edge
        assign cplx_fb = 1'b0;
    end else begin : g_inner
        assign cplx_fb = pad_in;
    end

    // Route data, enable and feedback for each configuration.
    always_comb begin
        case (cfg)
            CELL_REG_OUT: begin
                pad_out = ~q;
                pad_oe  = ~oe_n;
                fb_out  = q;
            end
            CELL_COMB_IO: begin
                pad_out = pol_sum;
                pad_oe  = en_term;
                fb_out  = pad_in;
            end
            CELL_CPLX_IO: begin
                pad_out = pol_sum;
                pad_oe  = en_term;
                fb_out  = cplx_fb;
            end
            default: begin
                pad_out = 1'b0;
                pad_oe  = 1'b0;
                fb_out  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/plc_out_cell.sv
// Module: plc_out_cell
// One output macrocell of a sum-of-products logic device. The AND array
// lies outside. The configuration inputs are static. The pin is split into
// out, enable and seen-on-pad signals.
module plc_out_cell
    import plc_cell_pkg::*;
#(
    parameter int NUM_PT    = 8,
    parameter bit EDGE_CELL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PT-1:0] pterm,
    input  logic              oe_n,
    input  logic              cfg_comb_sel,
    input  logic              cfg_arch_en,
    input  logic              cfg_pol_hi,
    input  logic              cfg_io_sel,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              fb_out
);

    cell_cfg_e cfg;
    logic      pol_sum;
    logic      q;

    plc_cfg_decode u_decode (
        .comb_sel (cfg_comb_sel),
        .arch_en  (cfg_arch_en),
        .io_sel   (cfg_io_sel),
        .cfg      (cfg)
    );

    plc_sum_term #(.NUM_PT(NUM_PT)) u_sum (
        .pterm   (pterm),
        .cfg     (cfg),
        .pol_hi  (cfg_pol_hi),
        .pol_sum (pol_sum)
    );

    plc_out_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_next (pol_sum),
        .q        (q)
    );

    plc_pad_drive #(.EDGE_CELL(EDGE_CELL)) u_drive (
        .cfg     (cfg),
        .pol_sum (pol_sum),
        .q       (q),
        .en_term (pterm[0]),
        .oe_n    (oe_n),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .fb_out  (fb_out)
    );

endmodule

// File: rtl/plc_out_cell_chk.sv
// Module: plc_out_cell_chk
// Checker bound to plc_out_cell. It works from the port values only and
// recomputes the expected sums from the configuration inputs.
module plc_out_cell_chk #(
    parameter int NUM_PT    = 8,
    parameter bit EDGE_CELL = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_PT-1:0] pterm,
    input logic              oe_n,
    input logic              cfg_comb_sel,
    input logic              cfg_arch_en,
    input logic              cfg_pol_hi,
    input logic              cfg_io_sel,
    input logic              pad_in,
    input logic              pad_out,
    input logic              pad_oe,
    input logic              fb_out
);

    logic is_reg_out;
    logic is_comb;
    logic is_cplx;
    logic exp_reg_pin;

    assign is_reg_out  = cfg_arch_en && !cfg_comb_sel && !cfg_io_sel;
    assign is_cplx     = cfg_arch_en && cfg_comb_sel;
    assign is_comb     = cfg_arch_en && (cfg_comb_sel || cfg_io_sel);
    assign exp_reg_pin = cfg_pol_hi ? (|pterm) : ~(|pterm);

    // R1: after a clocked edge the registered pin shows the captured sum
    a_r1_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && is_reg_out) |=> (!is_reg_out || pad_out == $past(exp_reg_pin)));

    // R2: the registered output's enable follows the shared pin
    a_r2_reg_oe: assert property (@(posedge clk) disable iff (!rst_n)
        is_reg_out |-> (pad_oe == !oe_n));

    // R3: the registered output's feedback is the complement of the pin data
    a_r3_reg_fb: assert property (@(posedge clk) disable iff (!rst_n)
        is_reg_out |-> (fb_out == !pad_out));

    // R4, R6: in combinatorial configurations the enable is product term 0
    a_r4_comb_oe: assert property (@(posedge clk) disable iff (!rst_n)
        is_comb |-> (pad_oe == pterm[0]));

    // R7: inner combinatorial cells feed back the pad value
    a_r7_pad_fb: assert property (@(posedge clk) disable iff (!rst_n)
        (is_comb && !(is_cplx && EDGE_CELL)) |-> (fb_out == pad_in));

    // R8: an outer cell in complex mode has no feedback
    a_r8_edge_fb: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cplx && EDGE_CELL) |-> !fb_out);

    // R9: an unsupported code leaves the cell fully quiet
    a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_arch_en |-> (!pad_oe && !pad_out && !fb_out));

    // R10: a reset edge clears the registered output
    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> (!is_reg_out || (pad_out && !fb_out)));

endmodule

bind plc_out_cell plc_out_cell_chk #(
    .NUM_PT    (NUM_PT),
    .EDGE_CELL (EDGE_CELL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pterm        (pterm),
    .oe_n         (oe_n),
    .cfg_comb_sel (cfg_comb_sel),
    .cfg_arch_en  (cfg_arch_en),
    .cfg_pol_hi   (cfg_pol_hi),
    .cfg_io_sel   (cfg_io_sel),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .fb_out       (fb_out)
);

// File: tb/plc_out_cell_test.sv
// Bench: plc_out_cell_test
// Sweeps every configuration against every product-term pattern on an
// inner cell and an outer cell. Expected values are computed in the bench.
module plc_out_cell_test;

    localparam int  NPT      = 8;
    localparam time CLK_HALF = 5ns;
    localparam time CLK_PER  = 2 * CLK_HALF;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPT-1:0] pterm = '0;
    logic           oe_n = 1'b1;
    logic           comb_sel = 1'b0;
    logic           arch_en = 1'b1;
    logic           pol_hi = 1'b1;
    logic           io_sel = 1'b0;
    logic           pad_in = 1'b0;
    logic           out_i, oe_i, fb_i;
    logic           out_e, oe_e, fb_e;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    plc_out_cell #(.NUM_PT(NPT), .EDGE_CELL(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .pterm(pterm), .oe_n(oe_n),
        .cfg_comb_sel(comb_sel), .cfg_arch_en(arch_en),
        .cfg_pol_hi(pol_hi), .cfg_io_sel(io_sel), .pad_in(pad_in),
        .pad_out(out_i), .pad_oe(oe_i), .fb_out(fb_i)
    );

    plc_out_cell #(.NUM_PT(NPT), .EDGE_CELL(1'b1)) uut_edge (
        .clk(clk), .rst_n(rst_n), .pterm(pterm), .oe_n(oe_n),
        .cfg_comb_sel(comb_sel), .cfg_arch_en(arch_en),
        .cfg_pol_hi(pol_hi), .cfg_io_sel(io_sel), .pad_in(pad_in),
        .pad_out(out_e), .pad_oe(oe_e), .fb_out(fb_e)
    );

    // Compare one output bit and record the result.
    task automatic check(input logic got, input logic exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    // Drive inputs half a cycle before the next rising edge.
    task automatic drive_at_fall(input logic [NPT-1:0] pt, input logic oen,
                                 input logic pin);
        @(negedge clk);
        pterm  = pt;
        oe_n   = oen;
        pad_in = pin;
    endtask

    initial begin : main
        logic held_valid;
        logic held_pin;
        held_valid = 1'b0;
        held_pin   = 1'b0;

        // R10: reset state in the registered-output configuration
        @(posedge clk); #1;
        check(out_i, 1'b1, "R10 reset pin");
        check(fb_i, 1'b0, "R10 reset feedback");

        // R10: load a 0 into the pin, then clear it with reset
        drive_at_fall(8'hFF, 1'b0, 1'b0);
        rst_n  = 1'b1;
        pol_hi = 1'b0;
        @(posedge clk); #1;
        check(out_i, 1'b0, "R10 loaded pin before reset");
        check(fb_i, 1'b1, "R10 loaded feedback before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(out_i, 1'b1, "R10 pin after reset");
        check(fb_i, 1'b0, "R10 feedback after reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Full sweep of configuration, product terms, enable pin and pad value.
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            comb_sel   = c[3];
            arch_en    = c[2];
            io_sel     = c[1];
            pol_hi     = c[0];
            held_valid = 1'b0;
            for (int p = 0; p < 256; p++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [NPT-1:0] pt;
                    logic s8, s7, reg_out, comb, cplx;
                    logic e_out, e_oe, e_fbi, e_fbe;
                    string tag_d, tag_o, tag_fi, tag_fe;
                    pt = NPT'(p);
                    drive_at_fall(pt, k[0], k[1]);
                    reg_out = arch_en && !comb_sel && !io_sel;
                    cplx    = arch_en && comb_sel;
                    comb    = arch_en && (comb_sel || io_sel);
                    // R1: the registered pin must not move between edges
                    #1;
                    if (reg_out && held_valid) begin
                        check(out_i, held_pin, "R1 pin held between edges");
                    end
                    s8 = |pt;
                    s7 = |pt[NPT-1:1];
                    if (reg_out) begin
                        e_out = pol_hi ? s8 : ~s8;
                        e_oe  = ~k[0];
                        e_fbi = ~e_out;
                        e_fbe = ~e_out;
                        tag_d = pol_hi ? "R1 registered pin" : "R5 R1 active-low registered pin";
                        tag_o = "R2 shared enable";
                        tag_fi = "R3 flip-flop feedback";
                        tag_fe = "R3 flip-flop feedback (outer)";
                    end else if (comb) begin
                        e_out = pol_hi ? s7 : ~s7;
                        e_oe  = pt[0];
                        e_fbi = k[1];
                        e_fbe = cplx ? 1'b0 : k[1];
                        tag_d = cplx ? (pol_hi ? "R6 complex pin" : "R5 R6 active-low complex pin")
                                     : (pol_hi ? "R4 I/O pin" : "R5 R4 active-low I/O pin");
                        tag_o = cplx ? "R6 term enable" : "R4 term enable";
                        tag_fi = "R7 pad feedback";
                        tag_fe = cplx ? "R8 outer cell feedback" : "R7 pad feedback (outer)";
                    end else begin
                        e_out = 1'b0;
                        e_oe  = 1'b0;
                        e_fbi = 1'b0;
                        e_fbe = 1'b0;
                        tag_d = "R9 disabled pin";
                        tag_o = "R9 disabled enable";
                        tag_fi = "R9 disabled feedback";
                        tag_fe = "R9 disabled feedback (outer)";
                    end
                    @(posedge clk); #1;
                    check(out_i, e_out, tag_d);
                    check(oe_i, e_oe, tag_o);
                    check(fb_i, e_fbi, tag_fi);
                    check(out_e, e_out, tag_d);
                    check(oe_e, e_oe, tag_o);
                    check(fb_e, e_fbe, tag_fe);
                    held_valid = reg_out;
                    held_pin   = e_out;
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PER * 190000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule